// File: doc/BRIEF.md
# Byte-Lane External Bus Strobe Generator

This block sits between a CPU-side access port and the pins of an external memory bus with a 24-bit address space. It accepts one request at a time. A request carries an address, a size (byte or word), a direction and write data. The block turns it into active-low control strobes: an address strobe, a single read strobe, and separate write strobes for the even (high) byte and the odd (low) byte. The write strobes stand in for address bit 0. The block also places the data on the correct byte lane and raises a per-lane drive enable for the pad logic.

A configuration input selects a 16-bit or an 8-bit external data bus. In 8-bit mode only the upper lane and the high-byte write strobe are used, and a word access becomes two consecutive byte cycles: the even byte first, then the odd byte. Addresses that fall inside the on-chip memory windows are accepted and completed without any external strobe. The windows are set by parameters.

Each external bus cycle lasts one clock. The read data present on the bus is captured at the end of the cycle. A one-clock response pulse returns the assembled read word after the last cycle. Wait insertion, chip-select decoding and pad tristate timing are handled elsewhere.

Top module: `extbus_strobe_gen`

## Requirements
- R1: All strobes are active low. After reset and whenever no bus cycle is in progress, `bus_as_n`, `bus_rd_n`, `bus_hwr_n` and `bus_lwr_n` are 1, `bus_lane_en` is 2'b00 and `req_ready` is 1.
- R2: A read drives `bus_as_n` and `bus_rd_n` low with both write strobes high and `bus_lane_en` = 2'b00. In 16-bit mode a read of either size is one bus cycle, and `rsp_rdata` returns all 16 bits of `bus_rdata`.
- R3: In 16-bit mode a byte write takes its data from `req_wdata[7:0]`. At an even address (A0=0) only `bus_hwr_n` goes low, the byte is driven on `bus_wdata[15:8]` and `bus_lane_en` = 2'b10. At an odd address only `bus_lwr_n` goes low, the byte is driven on `bus_wdata[7:0]` and `bus_lane_en` = 2'b01.
- R4: In 16-bit mode a word write drives both write strobes low in the same cycle, with `req_wdata[15:8]` (the even byte) on the upper lane, `req_wdata[7:0]` on the lower lane and `bus_lane_en` = 2'b11.
- R5: A word access to an odd address is aligned down: its bus address has bit 0 cleared (bit 0 is set again only for the second cycle in R7).
- R6: In 8-bit mode `bus_lwr_n` stays 1, `bus_lane_en[0]` stays 0 and every write uses `bus_hwr_n` and the upper lane. A byte read returns the byte from `bus_rdata[15:8]`, placed in `rsp_rdata[15:8]` for an even address or in `rsp_rdata[7:0]` for an odd one, with the other lane zero.
- R7: In 8-bit mode a word access takes two consecutive bus cycles. The first is at the aligned even address and carries `req_wdata[15:8]`, or fills `rsp_rdata[15:8]`. The second is at the even address plus one and carries `req_wdata[7:0]`, or fills `rsp_rdata[7:0]`.
- R8: An access whose aligned address lies in an internal window (default 0x000000–0x01FFFF and 0xFF8000–0xFFFFFF) keeps every strobe at 1 and `bus_lane_en` at 2'b00, and it completes with `rsp_rdata` = 0.
- R9: A request is accepted on the rising edge where `req_valid` and `req_ready` are both 1. The first bus cycle occupies the following clock, and each further cycle one clock more. `rsp_valid` is a one-clock pulse in the clock after the last bus cycle, when `req_ready` is already 1 again.
- R10: Write-data lanes that carry no write byte are driven to zero, and during reads `bus_wdata` is zero.
- R11: `cfg_bus16` is captured when a request is accepted. Changing it while the access is in progress has no effect on that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_bus16 | input | 1 | 1 = 16-bit external bus, 0 = 8-bit bus on upper lane |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | 24 | Byte address |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| bus_addr | output | 24 | External address of the current bus cycle |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_hwr_n | output | 1 | Even/high-byte write strobe, active low |
| bus_lwr_n | output | 1 | Odd/low-byte write strobe, active low |
| bus_wdata | output | 16 | Lane-steered write data |
| bus_lane_en | output | 2 | Lane drive enables, bit 1 upper lane, bit 0 lower lane |
| bus_rdata | input | 16 | Read data from the external bus |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Assembled read data (zero for writes and internal hits) |

## Verification
Most wrong internal state in this block shows up at the strobe pins in the very next clock. A held size, width or address bit that is wrong moves a write strobe to the wrong lane, or raises a strobe during an internal hit, during the first bus cycle. A stuck beat index or sequencer state shows up as a missing or extra second cycle, so the response pulse appears one clock early or late. Read-assembly faults appear only on `rsp_rdata` during the response clock. Each of these is therefore checked against per-cycle expectations at the pins, not only at completion.

// File: rtl/extbus_pkg.sv
package extbus_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_BEAT0 = 2'd1,
      ST_BEAT1 = 2'd2
   } seq_state_e;

   typedef struct packed {
      logic as_n;
      logic rd_n;
      logic hwr_n;
      logic lwr_n;
   } strobe_t;

   localparam strobe_t STROBE_IDLE = '{as_n: 1'b1, rd_n: 1'b1, hwr_n: 1'b1, lwr_n: 1'b1};
endpackage

// File: rtl/extbus_int_match.sv
module extbus_int_match #(
   parameter int ADDR_W = 24,
   parameter int NWIN   = 2,
   parameter logic [NWIN*ADDR_W-1:0] BASE_VEC = '0,
   parameter logic [NWIN*ADDR_W-1:0] LAST_VEC = '0
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   logic [NWIN-1:0] win_hit;

   for (genvar w = 0; w < NWIN; w++) begin : g_win
      localparam logic [ADDR_W-1:0] LO = BASE_VEC[w*ADDR_W +: ADDR_W];
      localparam logic [ADDR_W-1:0] HI = LAST_VEC[w*ADDR_W +: ADDR_W];
      if (LO > HI) begin : g_bad
         $error("internal window %0d has base above last address", w);
      end
      assign win_hit[w] = (addr >= LO) && (addr <= HI);
   end

   assign hit = |win_hit;
endmodule

// File: rtl/extbus_seq.sv
module extbus_seq
   import extbus_pkg::*;
#(
   parameter int ADDR_W    = 24,
   parameter int LANE_W    = 8,
   parameter bit NARROW_EN = 1'b1,
   localparam int DATA_W   = 2 * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_bus16,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr_al,
   input  logic              req_word,
   input  logic              req_write,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              req_int,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              beat_active,
   output logic              beat_idx,
   output logic [ADDR_W-1:0] h_addr,
   output logic              h_word,
   output logic              h_write,
   output logic [DATA_W-1:0] h_wdata,
   output logic              h_bus16,
   output logic              h_int,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata
);
   seq_state_e state_q, state_d;
   logic       eff_bus16;
   logic       accept;
   logic       split;
   logic       last_beat;
   logic [LANE_W-1:0] up_byte;

   if (NARROW_EN) begin : g_narrow
      assign eff_bus16 = cfg_bus16;
   end else begin : g_wide_only
      assign eff_bus16 = 1'b1;
   end

   assign req_ready   = (state_q == ST_IDLE);
   assign accept      = req_valid && req_ready;
   assign split       = h_word && !h_bus16;
   assign beat_active = (state_q != ST_IDLE);
   assign beat_idx    = (state_q == ST_BEAT1);
   assign last_beat   = (state_q == ST_BEAT1) || ((state_q == ST_BEAT0) && !split);
   assign up_byte     = bus_rdata[DATA_W-1:LANE_W];

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (accept) state_d = ST_BEAT0;
         ST_BEAT0: state_d = split ? ST_BEAT1 : ST_IDLE;
         ST_BEAT1: state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         h_addr  <= '0;
         h_word  <= 1'b0;
         h_write <= 1'b0;
         h_wdata <= '0;
         h_bus16 <= 1'b1;
         h_int   <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            h_addr  <= req_addr_al;
            h_word  <= req_word;
            h_write <= req_write;
            h_wdata <= req_wdata;
            h_bus16 <= eff_bus16;
            h_int   <= req_int;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= beat_active && last_beat;
         if (beat_active) begin
            if (h_int || h_write) begin
               rsp_rdata <= '0;
            end else if (h_bus16) begin
               rsp_rdata <= bus_rdata;
            end else if (h_word) begin
               if (beat_idx) rsp_rdata[LANE_W-1:0] <= up_byte;
               else          rsp_rdata <= {up_byte, {LANE_W{1'b0}}};
            end else if (h_addr[0]) begin
               rsp_rdata <= {{LANE_W{1'b0}}, up_byte};
            end else begin
               rsp_rdata <= {up_byte, {LANE_W{1'b0}}};
            end
         end
      end
   end

   // R7
   two_beats_only_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_BEAT1) |-> (h_word && !h_bus16));
   // R9
   rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
   // R9
   rsp_when_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> req_ready);
   // R11
   width_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_active && !accept) |=> $stable(h_bus16));
endmodule

// File: rtl/extbus_lane_steer.sv
module extbus_lane_steer
   import extbus_pkg::*;
#(
   parameter int ADDR_W  = 24,
   parameter int LANE_W  = 8,
   localparam int DATA_W = 2 * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              beat_active,
   input  logic              beat_idx,
   input  logic [ADDR_W-1:0] h_addr,
   input  logic              h_word,
   input  logic              h_write,
   input  logic [DATA_W-1:0] h_wdata,
   input  logic              h_bus16,
   input  logic              h_int,
   output logic [ADDR_W-1:0] bus_addr,
   output strobe_t           strb,
   output logic [DATA_W-1:0] bus_wdata,
   output logic [1:0]        bus_lane_en
);
   localparam logic [LANE_W-1:0] ZB = '0;
   logic ext;
   logic [LANE_W-1:0] hi_byte, lo_byte, narrow_byte;

   assign ext         = beat_active && !h_int;
   assign hi_byte     = h_wdata[DATA_W-1:LANE_W];
   assign lo_byte     = h_wdata[LANE_W-1:0];
   assign narrow_byte = (h_word && !beat_idx) ? hi_byte : lo_byte;

   always_comb begin
      bus_addr = h_addr;
      if (!h_bus16 && h_word) bus_addr[0] = beat_idx;
   end

   always_comb begin
      strb        = STROBE_IDLE;
      bus_wdata   = '0;
      bus_lane_en = 2'b00;
      if (ext) begin
         strb.as_n = 1'b0;
         if (!h_write) begin
            strb.rd_n = 1'b0;
         end else if (!h_bus16) begin
            strb.hwr_n  = 1'b0;
            bus_wdata   = {narrow_byte, ZB};
            bus_lane_en = 2'b10;
         end else if (h_word) begin
            strb.hwr_n  = 1'b0;
            strb.lwr_n  = 1'b0;
            bus_wdata   = h_wdata;
            bus_lane_en = 2'b11;
         end else if (h_addr[0]) begin
            strb.lwr_n  = 1'b0;
            bus_wdata   = {ZB, lo_byte};
            bus_lane_en = 2'b01;
         end else begin
            strb.hwr_n  = 1'b0;
            bus_wdata   = {lo_byte, ZB};
            bus_lane_en = 2'b10;
         end
      end
   end

   // R1
   strobe_needs_as_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!strb.rd_n || !strb.hwr_n || !strb.lwr_n) |-> !strb.as_n);
   // R2
   read_write_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !strb.rd_n |-> (strb.hwr_n && strb.lwr_n && bus_lane_en == 2'b00));
   // R5
   word_pair_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!strb.hwr_n && !strb.lwr_n) |-> !bus_addr[0]);
   // R6
   narrow_low_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_active && !h_bus16) |-> (strb.lwr_n && !bus_lane_en[0]));
   // R8
   internal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_active && h_int) |-> (strb == STROBE_IDLE && bus_lane_en == 2'b00));
endmodule

// File: rtl/extbus_strobe_gen.sv
module extbus_strobe_gen
   import extbus_pkg::*;
#(
   parameter int ADDR_W    = 24,
   parameter int LANE_W    = 8,
   parameter bit NARROW_EN = 1'b1,
   parameter int NWIN      = 2,
   parameter logic [NWIN*ADDR_W-1:0] INT_BASE = {24'hFF8000, 24'h000000},
   parameter logic [NWIN*ADDR_W-1:0] INT_LAST = {24'hFFFFFF, 24'h01FFFF},
   localparam int DATA_W   = 2 * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_bus16,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_word,
   input  logic              req_write,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_as_n,
   output logic              bus_rd_n,
   output logic              bus_hwr_n,
   output logic              bus_lwr_n,
   output logic [DATA_W-1:0] bus_wdata,
   output logic [1:0]        bus_lane_en,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata
);
   if (ADDR_W < 2) begin : g_bad_addr
      $error("ADDR_W must be at least 2");
   end
   if (LANE_W < 1) begin : g_bad_lane
      $error("LANE_W must be at least 1");
   end
   if (NWIN < 1) begin : g_bad_win
      $error("NWIN must be at least 1");
   end

   logic [ADDR_W-1:0] req_addr_al;
   logic              req_int;
   logic              beat_active, beat_idx;
   logic [ADDR_W-1:0] h_addr;
   logic              h_word, h_write, h_bus16, h_int;
   logic [DATA_W-1:0] h_wdata;
   strobe_t           strb;

   assign req_addr_al = req_word ? {req_addr[ADDR_W-1:1], 1'b0} : req_addr;

   extbus_int_match #(
      .ADDR_W(ADDR_W), .NWIN(NWIN), .BASE_VEC(INT_BASE), .LAST_VEC(INT_LAST)
   ) u_match (
      .addr (req_addr_al),
      .hit  (req_int)
   );

   extbus_seq #(
      .ADDR_W(ADDR_W), .LANE_W(LANE_W), .NARROW_EN(NARROW_EN)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_bus16   (cfg_bus16),
      .req_valid   (req_valid),
      .req_ready   (req_ready),
      .req_addr_al (req_addr_al),
      .req_word    (req_word),
      .req_write   (req_write),
      .req_wdata   (req_wdata),
      .req_int     (req_int),
      .bus_rdata   (bus_rdata),
      .beat_active (beat_active),
      .beat_idx    (beat_idx),
      .h_addr      (h_addr),
      .h_word      (h_word),
      .h_write     (h_write),
      .h_wdata     (h_wdata),
      .h_bus16     (h_bus16),
      .h_int       (h_int),
      .rsp_valid   (rsp_valid),
      .rsp_rdata   (rsp_rdata)
   );

   extbus_lane_steer #(
      .ADDR_W(ADDR_W), .LANE_W(LANE_W)
   ) u_steer (
      .clk         (clk),
      .rst_n       (rst_n),
      .beat_active (beat_active),
      .beat_idx    (beat_idx),
      .h_addr      (h_addr),
      .h_word      (h_word),
      .h_write     (h_write),
      .h_wdata     (h_wdata),
      .h_bus16     (h_bus16),
      .h_int       (h_int),
      .bus_addr    (bus_addr),
      .strb        (strb),
      .bus_wdata   (bus_wdata),
      .bus_lane_en (bus_lane_en)
   );

   assign bus_as_n  = strb.as_n;
   assign bus_rd_n  = strb.rd_n;
   assign bus_hwr_n = strb.hwr_n;
   assign bus_lwr_n = strb.lwr_n;

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (bus_as_n && bus_rd_n && bus_hwr_n && bus_lwr_n));
endmodule

// File: tb/extbus_strobe_gen_tb.sv
module extbus_strobe_gen_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_bus16 = 1'b1;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [23:0] req_addr = '0;
   logic        req_word = 1'b0;
   logic        req_write = 1'b0;
   logic [15:0] req_wdata = '0;
   logic [23:0] bus_addr;
   logic        bus_as_n, bus_rd_n, bus_hwr_n, bus_lwr_n;
   logic [15:0] bus_wdata;
   logic [1:0]  bus_lane_en;
   logic [15:0] bus_rdata = '0;
   logic        rsp_valid;
   logic [15:0] rsp_rdata;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #4 clk = ~clk;

   extbus_strobe_gen dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_bus16(cfg_bus16),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_word(req_word), .req_write(req_write), .req_wdata(req_wdata),
      .bus_addr(bus_addr), .bus_as_n(bus_as_n), .bus_rd_n(bus_rd_n),
      .bus_hwr_n(bus_hwr_n), .bus_lwr_n(bus_lwr_n), .bus_wdata(bus_wdata),
      .bus_lane_en(bus_lane_en), .bus_rdata(bus_rdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic run_access(input bit b16, input bit wr, input bit wd, input logic [23:0] a);
      logic [23:0] al;
      bit          inth;
      int          nb;
      logic [15:0] wv, rv0, rv1, erd, ewd, vv;
      logic [23:0] ea;
      logic [3:0]  estr;
      logic [1:0]  elane;
      string       tag;
      al   = wd ? {a[23:1], 1'b0} : a;
      inth = (al <= 24'h01FFFF) || (al >= 24'hFF8000);
      nb   = (!b16 && wd) ? 2 : 1;
      wv   = {8'h5A ^ a[7:0], 8'hC3 ^ a[15:8]};
      rv0  = '0;
      rv1  = '0;
      if (inth)             tag = "R8";
      else if (!b16 && wd)  tag = "R7";
      else if (!b16)        tag = "R6";
      else if (!wr)         tag = "R2";
      else if (wd)          tag = "R4";
      else                  tag = "R3";
      @(negedge clk);
      cfg_bus16 = b16;
      req_valid = 1'b1;
      req_addr  = a;
      req_word  = wd;
      req_write = wr;
      req_wdata = wv;
      chk(req_ready == 1'b1, "R9 ready before accept", {31'd0, req_ready}, 32'd1);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      req_addr  = ~a;
      req_wdata = ~wv;
      cfg_bus16 = !b16; // R11: must not affect the running access
      for (int k = 0; k < nb; k++) begin
         vv = 16'hA500 ^ a[15:0] ^ (k == 1 ? 16'h1111 : 16'h0000);
         bus_rdata = vv;
         if (k == 0) rv0 = vv; else rv1 = vv;
         ea = (!b16 && wd) ? {al[23:1], k[0]} : al;
         estr = 4'hF; elane = 2'b00; ewd = '0;
         if (!inth) begin
            estr[3] = 1'b0;
            if (!wr) begin
               estr[2] = 1'b0;
            end else if (!b16) begin
               estr[1] = 1'b0; elane = 2'b10;
               ewd = {(wd ? (k == 0 ? wv[15:8] : wv[7:0]) : wv[7:0]), 8'h00};
            end else if (wd) begin
               estr[1] = 1'b0; estr[0] = 1'b0; elane = 2'b11; ewd = wv;
            end else if (a[0]) begin
               estr[0] = 1'b0; elane = 2'b01; ewd = {8'h00, wv[7:0]};
            end else begin
               estr[1] = 1'b0; elane = 2'b10; ewd = {wv[7:0], 8'h00};
            end
         end
         chk({bus_as_n, bus_rd_n, bus_hwr_n, bus_lwr_n} == estr, {tag, " strobes"},
             {28'd0, bus_as_n, bus_rd_n, bus_hwr_n, bus_lwr_n}, {28'd0, estr});
         chk(bus_lane_en == elane, {tag, " lane enable"}, {30'd0, bus_lane_en}, {30'd0, elane});
         chk(bus_wdata == ewd, "R10 write lanes", {16'd0, bus_wdata}, {16'd0, ewd});
         if (!inth)
            chk(bus_addr == ea, wd ? "R5 aligned address" : "R9 bus address", {8'd0, bus_addr}, {8'd0, ea});
         chk(rsp_valid == 1'b0, "R9 no early response", {31'd0, rsp_valid}, 32'd0);
         @(posedge clk);
         @(negedge clk);
      end
      if (wr || inth)   erd = '0;
      else if (b16)     erd = rv0;
      else if (wd)      erd = {rv0[15:8], rv1[15:8]};
      else if (a[0])    erd = {8'h00, rv0[15:8]};
      else              erd = {rv0[15:8], 8'h00};
      chk(rsp_valid == 1'b1, "R9 response pulse", {31'd0, rsp_valid}, 32'd1);
      chk(rsp_rdata == erd, {tag, " read data"}, {16'd0, rsp_rdata}, {16'd0, erd});
      chk({bus_as_n, bus_rd_n, bus_hwr_n, bus_lwr_n, bus_lane_en} == 6'b111100, "R1 idle strobes",
          {26'd0, bus_as_n, bus_rd_n, bus_hwr_n, bus_lwr_n, bus_lane_en}, 32'h3C);
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R9 response ends", {31'd0, rsp_valid}, 32'd0);
   endtask

   logic [23:0] addrs [8];

   initial begin
      addrs[0] = 24'h020000; addrs[1] = 24'h01FFFF; addrs[2] = 24'h01FFFE;
      addrs[3] = 24'h7ABCD1; addrs[4] = 24'h7ABCD2; addrs[5] = 24'hFF7FFF;
      addrs[6] = 24'hFF8000; addrs[7] = 24'hFF7FFE;
      repeat (3) @(negedge clk);
      chk({bus_as_n, bus_rd_n, bus_hwr_n, bus_lwr_n} == 4'hF, "R1 reset strobes",
          {28'd0, bus_as_n, bus_rd_n, bus_hwr_n, bus_lwr_n}, 32'hF);
      chk(rsp_valid == 1'b0, "R1 reset response", {31'd0, rsp_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1 && bus_lane_en == 2'b00, "R1 ready after reset",
          {29'd0, req_ready, bus_lane_en}, 32'h4);
      for (int b = 0; b < 2; b++)
         for (int w = 0; w < 2; w++)
            for (int d = 0; d < 2; d++)
               for (int i = 0; i < 8; i++)
                  run_access(b[0], w[0], d[0], addrs[i]);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 100000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule